// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Frozen User Copy

This block keeps time of day and the calendar as a chain of BCD counters: hundredths of a second, seconds, minutes, hours in 24-hour form, day of week, date, month, year and a two-bit century. A 100 Hz enable input advances the chain. Each carry ripples through every field in the same clock cycle. The date rolls over according to the length of the current month, and February takes a leap day in any year divisible by four.

Software never reads the counters directly. It reads a user copy of the eight bytes. While a bus master is reading or writing clock addresses, the user copy is frozen so that a multi-byte read sees one coherent time. Counter changes that occur during the freeze are remembered and applied in one transfer when the freeze ends. The freeze ends when the access moves off the clock range, or earlier on a bus stop pulse.

Any write to a clock byte clears the hundredths and restarts the sub-second division. This includes a write that only touches the control bits stored in those bytes.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset, both the counters and the user copy read, from byte 0 to byte 7: 00, 00, 00, 00, 01, 01, 01, 00.
- R2: Byte 0 (hundredths) counts 00 to 99 in BCD on each cycle with `tick_i` high. Its carry ripples in the same cycle through seconds (byte 1, bits 6:0, 00–59), minutes (byte 2, bits 6:0, 00–59) and hours (byte 3, bits 5:0, 00–23).
- R3: When the hours wrap from 23 to 00, the day of week (byte 4, bits 2:0) steps from 1 to 7 and wraps from 7 back to 1.
- R4: The date (byte 5, bits 5:0) wraps to 01 and the month (byte 6, bits 4:0, 01–12) advances after day 30 in April, June, September and November, and after day 31 in the other months. February ends after day 28, or after day 29 when the BCD year is divisible by 4.
- R5: When December wraps to January, the year (byte 7) advances. When the year wraps from 99 to 00, the century field (byte 6, bits 7:6) increments modulo 4.
- R6: A write with `wr_en_i` stores `wr_data_i` in byte `wr_addr_i`, except that byte 0 always becomes 00. Every write also clears byte 0, and a tick in the same cycle is discarded.
- R7: While byte 1 bit 7 (halt) is 1, ticks have no effect on any byte. After the bit is written back to 0, counting resumes.
- R8: Non-counting bits are kept as they are when the counters roll over: byte 1 bit 7, byte 2 bit 7 (fail-interrupt enable), byte 3 bits 7:6, byte 4 bits 7:3, byte 5 bits 7:6, and byte 6 bits 7:5 apart from the century increment.
- R9: While `rd_busy_i` is high and `bus_stop_i` is low, `user_bytes_o` holds its value. Counter changes from ticks and writes stay pending, and the latest values are transferred in a single step in the cycle after the freeze ends.
- R10: A one-cycle `bus_stop_i` pulse releases the freeze for that cycle even while `rd_busy_i` stays high.
- R11: When not frozen, a counter change appears on `user_bytes_o` exactly one clock after it appears in the counters. That is two rising edges after the tick or write is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 100 Hz count enable, one cycle per hundredth |
| wr_en_i | input | 1 | Clock-byte write strobe |
| wr_addr_i | input | 3 | Byte index 0–7 of the write |
| wr_data_i | input | 8 | Write data |
| rd_busy_i | input | 1 | Bus access currently in the clock address range |
| bus_stop_i | input | 1 | One-cycle pulse on a bus stop condition |
| user_bytes_o | output | 64 | User copy, byte n on bits 8n+7:8n |

## Verification
A tick or write sampled on one rising edge changes the counters on that edge. The change reaches `user_bytes_o` on the next rising edge if no freeze is active; otherwise it waits until the cycle after the release. The bench drives and samples on falling edges. Each scenario applies its stimulus and then spends one extra idle cycle before reading the user copy. The latency scenario reads once after the first edge, expecting the old value, and once after the second edge, expecting the new one. Freeze scenarios read inside the held window and again exactly one cycle after the release or stop pulse.

// File: rtl/bcdtk_pkg.sv
package bcdtk_pkg;
    localparam int BYTE_W    = 8;
    localparam int CLK_BYTES = 8;
    localparam int ADDR_W    = $clog2(CLK_BYTES);

    localparam int IDX_HUND = 0;
    localparam int IDX_SEC  = 1;
    localparam int IDX_MIN  = 2;
    localparam int IDX_HOUR = 3;
    localparam int IDX_DOW  = 4;
    localparam int IDX_DATE = 5;
    localparam int IDX_MON  = 6;
    localparam int IDX_YEAR = 7;

    typedef logic [BYTE_W-1:0] tk_byte_t;
    typedef tk_byte_t [CLK_BYTES-1:0] clk_bytes_t;

    typedef struct packed {
        clk_bytes_t bytes;
    } tk_state_t;

    typedef struct packed {
        clk_bytes_t user;
        logic       pending;
    } shd_state_t;

    // year, month, date, dow, hour, min, sec, hundredths
    localparam clk_bytes_t RESET_BYTES =
        {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};

    // A BCD year is a multiple of four when an even tens digit pairs
    // with 0/4/8, or an odd tens digit pairs with 2/6.
    function automatic logic bcd_leap(input tk_byte_t yr);
        logic [3:0] ones;
        ones = yr[3:0];
        if (!yr[4]) return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
        else        return (ones == 4'd2) || (ones == 4'd6);
    endfunction
endpackage

// File: rtl/bcdtk_field_inc.sv
module bcdtk_field_inc #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] hi_i,
    input  logic         inc_i,
    output logic [W-1:0] nxt_o,
    output logic         wrap_o
);
    logic [7:0] cur8;
    logic [7:0] nxt8;

    always_comb begin
        cur8 = 8'(cur_i);
        if (cur8[3:0] >= 4'd9) nxt8 = {cur8[7:4] + 4'd1, 4'd0};
        else                   nxt8 = cur8 + 8'd1;

        wrap_o = inc_i && (cur_i >= hi_i);
        if (!inc_i)      nxt_o = cur_i;
        else if (wrap_o) nxt_o = lo_i;
        else             nxt_o = nxt8[W-1:0];
    end
endmodule

// File: rtl/bcdtk_month_len.sv
module bcdtk_month_len
    import bcdtk_pkg::*;
(
    input  logic [4:0] month_i,
    input  tk_byte_t   year_i,
    output logic [5:0] last_day_o
);
    always_comb begin
        unique case (month_i)
            5'h02:                      last_day_o = bcd_leap(year_i) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_day_o = 6'h30;
            default:                    last_day_o = 6'h31;
        endcase
    end
endmodule

// File: rtl/bcdtk_shadow.sv
module bcdtk_shadow
    import bcdtk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  clk_bytes_t src_i,
    input  logic       update_i,
    input  logic       freeze_i,
    output clk_bytes_t user_o,
    output logic       pending_o
);
    shd_state_t shd_d, shd_q;
    logic       xfer;

    always_comb begin
        shd_d = shd_q;
        xfer  = shd_q.pending && !freeze_i;
        if (xfer) shd_d.user = src_i;
        // an update landing in the transfer cycle stays pending for the next
        shd_d.pending = update_i || (shd_q.pending && !xfer);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_q.user    <= RESET_BYTES;
            shd_q.pending <= 1'b0;
        end else begin
            shd_q <= shd_d;
        end
    end

    assign user_o    = shd_q.user;
    assign pending_o = shd_q.pending;
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
    import bcdtk_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick_i,
    input  logic                        wr_en_i,
    input  logic [ADDR_W-1:0]           wr_addr_i,
    input  logic [BYTE_W-1:0]           wr_data_i,
    input  logic                        rd_busy_i,
    input  logic                        bus_stop_i,
    output logic [CLK_BYTES*BYTE_W-1:0] user_bytes_o
);
    tk_state_t  int_d, int_q;
    clk_bytes_t int_bytes;
    clk_bytes_t shd_user;
    logic       shd_pending;

    logic       run, changed, freeze;
    logic [7:0] h_nxt, y_nxt;
    logic [6:0] s_nxt, m_nxt;
    logic [5:0] hr_nxt, dt_nxt, last_day;
    logic [4:0] mo_nxt;
    logic [2:0] dw_nxt;
    logic       h_wrap, s_wrap, m_wrap, hr_wrap, dw_wrap, dt_wrap, mo_wrap, y_wrap;

    assign int_bytes = int_q.bytes;
    assign run       = tick_i && !int_bytes[IDX_SEC][7] && !wr_en_i;
    assign changed   = run || wr_en_i;
    assign freeze    = rd_busy_i && !bus_stop_i;

    bcdtk_field_inc #(.W(8)) u_hund (
        .cur_i(int_bytes[IDX_HUND]), .lo_i(8'h00), .hi_i(8'h99),
        .inc_i(run), .nxt_o(h_nxt), .wrap_o(h_wrap));

    bcdtk_field_inc #(.W(7)) u_sec (
        .cur_i(int_bytes[IDX_SEC][6:0]), .lo_i(7'h00), .hi_i(7'h59),
        .inc_i(h_wrap), .nxt_o(s_nxt), .wrap_o(s_wrap));

    bcdtk_field_inc #(.W(7)) u_min (
        .cur_i(int_bytes[IDX_MIN][6:0]), .lo_i(7'h00), .hi_i(7'h59),
        .inc_i(s_wrap), .nxt_o(m_nxt), .wrap_o(m_wrap));

    bcdtk_field_inc #(.W(6)) u_hour (
        .cur_i(int_bytes[IDX_HOUR][5:0]), .lo_i(6'h00), .hi_i(6'h23),
        .inc_i(m_wrap), .nxt_o(hr_nxt), .wrap_o(hr_wrap));

    bcdtk_field_inc #(.W(3)) u_dow (
        .cur_i(int_bytes[IDX_DOW][2:0]), .lo_i(3'd1), .hi_i(3'd7),
        .inc_i(hr_wrap), .nxt_o(dw_nxt), .wrap_o(dw_wrap));

    bcdtk_month_len u_mlen (
        .month_i(int_bytes[IDX_MON][4:0]), .year_i(int_bytes[IDX_YEAR]),
        .last_day_o(last_day));

    bcdtk_field_inc #(.W(6)) u_date (
        .cur_i(int_bytes[IDX_DATE][5:0]), .lo_i(6'h01), .hi_i(last_day),
        .inc_i(hr_wrap), .nxt_o(dt_nxt), .wrap_o(dt_wrap));

    bcdtk_field_inc #(.W(5)) u_mon (
        .cur_i(int_bytes[IDX_MON][4:0]), .lo_i(5'h01), .hi_i(5'h12),
        .inc_i(dt_wrap), .nxt_o(mo_nxt), .wrap_o(mo_wrap));

    bcdtk_field_inc #(.W(8)) u_year (
        .cur_i(int_bytes[IDX_YEAR]), .lo_i(8'h00), .hi_i(8'h99),
        .inc_i(mo_wrap), .nxt_o(y_nxt), .wrap_o(y_wrap));

    always_comb begin
        int_d = int_q;
        if (wr_en_i) begin
            // a write restarts the sub-second division: hundredths to 00
            int_d.bytes[wr_addr_i] = wr_data_i;
            int_d.bytes[IDX_HUND]  = '0;
        end else if (run) begin
            int_d.bytes[IDX_HUND] = h_nxt;
            int_d.bytes[IDX_SEC]  = {int_bytes[IDX_SEC][7],    s_nxt};
            int_d.bytes[IDX_MIN]  = {int_bytes[IDX_MIN][7],    m_nxt};
            int_d.bytes[IDX_HOUR] = {int_bytes[IDX_HOUR][7:6], hr_nxt};
            int_d.bytes[IDX_DOW]  = {int_bytes[IDX_DOW][7:3],  dw_nxt};
            int_d.bytes[IDX_DATE] = {int_bytes[IDX_DATE][7:6], dt_nxt};
            int_d.bytes[IDX_MON]  = {int_bytes[IDX_MON][7:6] + {1'b0, y_wrap},
                                     int_bytes[IDX_MON][5], mo_nxt};
            int_d.bytes[IDX_YEAR] = y_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) int_q.bytes <= RESET_BYTES;
        else        int_q       <= int_d;
    end

    bcdtk_shadow u_shadow (
        .clk(clk), .rst_n(rst_n), .src_i(int_bytes), .update_i(changed),
        .freeze_i(freeze), .user_o(shd_user), .pending_o(shd_pending));

    assign user_bytes_o = shd_user;

    // dw_wrap is the end of a week; nothing downstream consumes it
    logic unused_ok;
    assign unused_ok = dw_wrap;
endmodule

// File: rtl/bcd_timekeeper_checker.sv
module bcd_timekeeper_checker
    import bcdtk_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en_i,
    input logic       rd_busy_i,
    input logic       bus_stop_i,
    input clk_bytes_t int_bytes,
    input clk_bytes_t user_bytes,
    input logic       pending
);
    p_hund_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> int_bytes[IDX_HUND] == 8'h00);

    p_hund_bcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int_bytes[IDX_HUND][3:0] <= 4'd9);

    p_halted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_bytes[IDX_SEC][7] && !wr_en_i) |=> $stable(int_bytes));

    p_frozen_user_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy_i && !bus_stop_i) |=> $stable(user_bytes));

    p_transfer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && (!rd_busy_i || bus_stop_i)) |=> user_bytes == $past(int_bytes));

    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && bus_stop_i) |=> !$stable(user_bytes) || user_bytes == $past(int_bytes));
endmodule

bind bcd_timekeeper bcd_timekeeper_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .rd_busy_i(rd_busy_i),
    .bus_stop_i(bus_stop_i), .int_bytes(int_bytes), .user_bytes(shd_user),
    .pending(shd_pending));

// File: tb/bcd_timekeeper_bench.sv
`timescale 1ns/1ps
module bcd_timekeeper_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_busy = 1'b0;
    logic        bus_stop = 1'b0;
    logic [63:0] ub;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bcd_timekeeper u_bcd_timekeeper (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_busy_i(rd_busy),
        .bus_stop_i(bus_stop), .user_bytes_o(ub));

    function automatic logic [7:0] ubyte(input int i);
        return ub[8*i +: 8];
    endfunction

    task automatic chk(input string tag, input int idx, input logic [7:0] exp);
        checks++;
        if (ubyte(idx) !== exp) begin
            errors++;
            $display("FAIL %s byte%0d actual=%02h expected=%02h", tag, idx, ubyte(idx), exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // n tick cycles, then one idle cycle so the user copy has caught up
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
        end
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] hr, input logic [7:0] dt,
                            input logic [7:0] mo, input logic [7:0] yr);
        wr(3'd1, 8'h59); wr(3'd2, 8'h59); wr(3'd3, hr);
        wr(3'd5, dt); wr(3'd6, mo); wr(3'd7, yr);
        settle();
    endtask

    task automatic t_reset();
        chk("R1", 0, 8'h00); chk("R1", 1, 8'h00); chk("R1", 2, 8'h00); chk("R1", 3, 8'h00);
        chk("R1", 4, 8'h01); chk("R1", 5, 8'h01); chk("R1", 6, 8'h01); chk("R1", 7, 8'h00);
    endtask

    task automatic t_latency();
        wr(3'd0, 8'h00); settle();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        chk("R11 one edge", 0, 8'h00);
        @(negedge clk);
        chk("R11 two edges", 0, 8'h01);
    endtask

    task automatic t_ripple();
        set_time(8'h22, 8'h01, 8'h01, 8'h00);
        ticks(99);
        chk("R2", 0, 8'h99); chk("R2", 1, 8'h59);
        ticks(1);
        chk("R2", 0, 8'h00); chk("R2", 1, 8'h00); chk("R2", 2, 8'h00);
        chk("R2", 3, 8'h23); chk("R2", 5, 8'h01);
    endtask

    task automatic t_midnight();
        wr(3'd4, 8'h07);
        set_time(8'h23, 8'h01, 8'h01, 8'h00);
        ticks(100);
        chk("R3", 3, 8'h00); chk("R3", 4, 8'h01); chk("R3", 5, 8'h02);
    endtask

    task automatic month_case(input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] yr,
                              input logic [7:0] edt, input logic [7:0] emo);
        set_time(8'h23, dt, mo, yr);
        ticks(100);
        chk("R4", 5, edt); chk("R4", 6, emo);
    endtask

    task automatic t_months();
        month_case(8'h30, 8'h04, 8'h10, 8'h01, 8'h05);
        month_case(8'h30, 8'h05, 8'h10, 8'h31, 8'h05);
        month_case(8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
        month_case(8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
        month_case(8'h29, 8'h02, 8'h24, 8'h01, 8'h03);
    endtask

    task automatic t_century();
        set_time(8'h23, 8'h31, 8'hD2, 8'h99);
        ticks(100);
        chk("R5", 5, 8'h01); chk("R5", 6, 8'h01); chk("R5", 7, 8'h00);
        set_time(8'h23, 8'h31, 8'h52, 8'h99);
        ticks(100);
        chk("R5", 6, 8'h81); chk("R5", 7, 8'h00);
    endtask

    task automatic t_write();
        wr(3'd0, 8'h45); settle();
        chk("R6 hund forced", 0, 8'h00);
        ticks(37);
        chk("R6 pre", 0, 8'h37);
        @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h42;
        @(negedge clk); tick = 1'b0; wr_en = 1'b0;
        settle();
        chk("R6 clear", 0, 8'h00); chk("R6 data", 1, 8'h42);
        wr(3'd4, 8'h05); settle();
        chk("R6 day", 4, 8'h05);
    endtask

    task automatic t_halt();
        wr(3'd1, 8'h90); settle();
        ticks(50);
        chk("R7 halted", 0, 8'h00); chk("R7 halted", 1, 8'h90);
        wr(3'd1, 8'h10); settle();
        ticks(5);
        chk("R7 resumed", 0, 8'h05); chk("R7 resumed", 1, 8'h10);
    endtask

    task automatic t_ctrl_bits();
        wr(3'd4, 8'hF3);
        set_time(8'h23, 8'h05, 8'h41, 8'h10);
        wr(3'd2, 8'hD9); settle();
        ticks(100);
        chk("R8", 2, 8'h80); chk("R8", 3, 8'h00); chk("R8", 4, 8'hF4);
        chk("R8", 5, 8'h06); chk("R8", 6, 8'h41);
    endtask

    task automatic t_freeze();
        logic [7:0] old_sec;
        wr(3'd0, 8'h00); settle();
        old_sec = ubyte(1);
        @(negedge clk); rd_busy = 1'b1;
        ticks(30);
        chk("R9 held", 0, 8'h00);
        @(negedge clk); rd_busy = 1'b0;
        @(negedge clk);
        chk("R9 released", 0, 8'h30);
        @(negedge clk); rd_busy = 1'b1;
        wr(3'd1, 8'h33); settle();
        chk("R9 write held", 1, old_sec);
        @(negedge clk); rd_busy = 1'b0;
        @(negedge clk);
        chk("R9 write released", 1, 8'h33); chk("R9 write released", 0, 8'h00);
    endtask

    task automatic t_stop_pulse();
        wr(3'd0, 8'h00); settle();
        @(negedge clk); rd_busy = 1'b1;
        ticks(10);
        chk("R10 held", 0, 8'h00);
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
        chk("R10 stop", 0, 8'h10);
        ticks(5);
        chk("R10 held again", 0, 8'h10);
        @(negedge clk); rd_busy = 1'b0;
        @(negedge clk);
        chk("R10 final", 0, 8'h15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_ripple();
        t_midnight();
        t_months();
        t_century();
        t_write();
        t_halt();
        t_ctrl_bits();
        t_freeze();
        t_stop_pulse();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule